// File: doc/BRIEF.md
# Core Memory Cycle Controller

This block sequences every access to a word-organised coincident-current magnetic store. A host hands it one request at a time: an operation code, a word address and write data. The block then runs a full memory cycle. First a destructive sense phase drives the addressed X and Y lines toward the zero state. Then a restore phase drives the same lines in the opposite direction and uses per-bit inhibit enables to keep the zero bits from flipping. The storage itself is a behavioural model inside the block. Each stored bit lives on its own plane, so the whole word moves in parallel. Any word that is sensed is cleared.

There are three operations: a plain read, which puts the sensed word back; a write, which drops the sensed word and stores the host data; and a read-increment, which returns the original word and stores that word plus one. A single line is shared between sensing and inhibiting. Its mode output reports which of the two jobs it is doing. A sense strobe marks the clock in which the sensed word is captured.

The sequencer has four states. IDLE moves to SENSE when a request is accepted. SENSE moves to RESTORE after ACCESS_DLY clocks. RESTORE moves to DONE after WRITE_LEN clocks. DONE always returns to IDLE after one clock.

Top module: `core_cycle_ctrl`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1. `rsp_done`, `sense_strobe`, `sel_dir`, `line_mode`, every `sel_x`/`sel_y` bit and every `inh_en` bit are 0.
- R2: The sense phase lasts exactly ACCESS_DLY clocks with `sel_dir`=0. `sense_strobe` is high in the last of those clocks only, once per access.
- R3: `line_mode` is 0 (sense) in the sense phase and when idle. It is 1 (inhibit) throughout the restore phase.
- R4: The restore phase begins in the clock right after the strobe. It lasts exactly WRITE_LEN clocks with `sel_dir`=1 and the same selected lines as the sense phase.
- R5: During the restore phase, `inh_en[i]` is 1 exactly when bit i of the value being stored is 0. Outside the restore phase every `inh_en` bit is 0.
- R6: Operation code 2'b00 (read) returns the stored word on `rsp_rdata` and leaves it stored unchanged.
- R7: Operation code 2'b01 (write) stores `req_wdata`. `rsp_rdata` keeps its previous value.
- R8: Operation code 2'b10 (read-increment) returns the original word and stores that word plus one, modulo 2^DATA_W, so 0xFF becomes 0x00 for 8 bits.
- R9: Operation code 2'b11 behaves exactly as a read.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_done` is a one-clock pulse that rises ACCESS_DLY+WRITE_LEN clocks after the accepting edge. `req_ready` is 0 from the accepting edge until the clock after `rsp_done`, and requests presented in that window are ignored.
- R11: While an access is in progress, the low ADDR_W/2 address bits pick the single active `sel_x` line (bit index equal to that field). The remaining high bits pick the single active `sel_y` line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 read-increment, 11 read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for a write |
| req_ready | output | 1 | Block can accept a request |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_rdata | output | DATA_W | Word sensed by the last read-type access |
| sel_x | output | 2**(ADDR_W/2) | X half-select enables, one-hot while driving |
| sel_y | output | 2**(ADDR_W-ADDR_W/2) | Y half-select enables, one-hot while driving |
| sel_dir | output | 1 | Drive direction: 0 toward zero (sense), 1 toward one (restore) |
| inh_en | output | DATA_W | Per-plane inhibit enables |
| line_mode | output | 1 | Shared line mode: 0 sense, 1 inhibit |
| sense_strobe | output | 1 | Sense capture strobe |

## Verification
Counting from the accepting edge, the sense-phase outputs are due one clock later. The strobe is due in the ACCESS_DLY-th clock after the accepting edge, and the restore outputs in the WRITE_LEN clocks that follow. `rsp_done` and the returned data are due in clock ACCESS_DLY+WRITE_LEN+1, and `req_ready` comes back one clock after that. The bench drives requests on falling edges and counts falling edges from the accepting rising edge. At each count it compares the whole output set against the phase that count must fall in. It sweeps all sixteen addresses, with expected words computed arithmetically, and follows up with increment wrap, write, alternate-code and busy-request cases.

// File: rtl/core_cyc_pkg.sv
package core_cyc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_INC   = 2'b10,
        OP_RDALT = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SENSE,
        ST_RESTORE,
        ST_DONE
    } cyc_state_e;

endpackage

// File: rtl/core_cyc_fsm.sv
module core_cyc_fsm
    import core_cyc_pkg::*;
#(
    parameter int ACCESS_DLY = 3,
    parameter int WRITE_LEN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ph_sense,
    output logic ph_restore,
    output logic strobe,
    output logic done,
    output logic ready
);
    localparam int LONGEST = (ACCESS_DLY > WRITE_LEN) ? ACCESS_DLY : WRITE_LEN;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] SENSE_LAST   = CNT_W'(ACCESS_DLY - 1);
    localparam logic [CNT_W-1:0] RESTORE_LAST = CNT_W'(WRITE_LEN - 1);

    cyc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)                 state_d = ST_SENSE;
            ST_SENSE:   if (cnt_q == SENSE_LAST)   state_d = ST_RESTORE;
            ST_RESTORE: if (cnt_q == RESTORE_LAST) state_d = ST_DONE;
            ST_DONE:                               state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ph_sense   = 1'b0;
        ph_restore = 1'b0;
        strobe     = 1'b0;
        done       = 1'b0;
        ready      = 1'b0;
        unique case (state_q)
            ST_IDLE:    ready = 1'b1;
            ST_SENSE: begin
                ph_sense = 1'b1;
                strobe   = (cnt_q == SENSE_LAST);
            end
            ST_RESTORE: ph_restore = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/core_plane_array.sv
module core_plane_array #(
    parameter int XN     = 4,
    parameter int YN     = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [XN-1:0]     sel_x,
    input  logic [YN-1:0]     sel_y,
    input  logic              sel_dir,
    input  logic              clear_now,
    input  logic [DATA_W-1:0] inh_en,
    output logic [DATA_W-1:0] sense_bits
);
    localparam int NW = XN * YN;

    logic [DATA_W-1:0] word_sense [NW];

    for (genvar iy = 0; iy < YN; iy++) begin : g_row
        for (genvar ix = 0; ix < XN; ix++) begin : g_col
            logic              hit;
            logic [DATA_W-1:0] cores_q;
            assign hit = sel_x[ix] & sel_y[iy];
            always_ff @(posedge clk) begin
                if (hit && !sel_dir && clear_now) cores_q <= '0;
                else if (hit && sel_dir)          cores_q <= cores_q | ~inh_en;
            end
            assign word_sense[iy*XN + ix] = (hit && !sel_dir) ? cores_q : '0;
        end
    end

    always_comb begin
        sense_bits = '0;
        for (int k = 0; k < NW; k++) sense_bits = sense_bits | word_sense[k];
    end

endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl
    import core_cyc_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int ACCESS_DLY = 3,
    parameter int WRITE_LEN  = 2,
    localparam int XA_W = ADDR_W / 2,
    localparam int YA_W = ADDR_W - XA_W,
    localparam int XN   = 2 ** XA_W,
    localparam int YN   = 2 ** YA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [XN-1:0]     sel_x,
    output logic [YN-1:0]     sel_y,
    output logic              sel_dir,
    output logic [DATA_W-1:0] inh_en,
    output logic              line_mode,
    output logic              sense_strobe
);
    logic              ph_sense, ph_restore, accept, driving;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, sensed_q, store_val, sense_bits;

    assign accept  = req_valid & req_ready;
    assign driving = ph_sense | ph_restore;

    core_cyc_fsm #(.ACCESS_DLY(ACCESS_DLY), .WRITE_LEN(WRITE_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .ph_sense   (ph_sense),
        .ph_restore (ph_restore),
        .strobe     (sense_strobe),
        .done       (rsp_done),
        .ready      (req_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_READ;
            addr_q    <= '0;
            wdata_q   <= '0;
            sensed_q  <= '0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                op_q    <= op_e'(req_op);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sense_strobe) begin
                sensed_q <= sense_bits;
                if (op_q != OP_WRITE) rsp_rdata <= sense_bits;
            end
        end
    end

    always_comb begin
        unique case (op_q)
            OP_WRITE: store_val = wdata_q;
            OP_INC:   store_val = sensed_q + 1'b1;
            default:  store_val = sensed_q;
        endcase
    end

    assign sel_x     = driving ? (XN'(1) << addr_q[XA_W-1:0])      : '0;
    assign sel_y     = driving ? (YN'(1) << addr_q[ADDR_W-1:XA_W]) : '0;
    assign sel_dir   = ph_restore;
    assign line_mode = ph_restore;
    assign inh_en    = ph_restore ? ~store_val : '0;

    core_plane_array #(.XN(XN), .YN(YN), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .sel_x      (sel_x),
        .sel_y      (sel_y),
        .sel_dir    (sel_dir),
        .clear_now  (sense_strobe),
        .inh_en     (inh_en),
        .sense_bits (sense_bits)
    );

endmodule

// File: rtl/core_cycle_chk.sv
module core_cycle_chk #(
    parameter int XN     = 4,
    parameter int YN     = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [XN-1:0]     sel_x,
    input logic [YN-1:0]     sel_y,
    input logic              sel_dir,
    input logic [DATA_W-1:0] inh_en,
    input logic              line_mode,
    input logic              sense_strobe
);
    p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_x) && $onehot0(sel_y) && ($countones(sel_x) == $countones(sel_y)));

    p_strobe_in_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sense_strobe |-> (!sel_dir && !line_mode && (|sel_x)));

    p_sense_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sel_x) && !sel_dir) |-> !line_mode);

    p_restore_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sense_strobe |=> (sel_dir && line_mode && (|sel_x)));

    p_inhibit_restore_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|inh_en) |-> (sel_dir && line_mode && (|sel_x)));

    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));
endmodule

bind core_cycle_ctrl core_cycle_chk #(.XN(XN), .YN(YN), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_done     (rsp_done),
    .sel_x        (sel_x),
    .sel_y        (sel_y),
    .sel_dir      (sel_dir),
    .inh_en       (inh_en),
    .line_mode    (line_mode),
    .sense_strobe (sense_strobe)
);

// File: tb/tb_core_cycle_ctrl.sv
module tb_core_cycle_ctrl;
    localparam int AW = 4, DW = 8, AD = 3, WL = 2;
    localparam int XN = 4, YN = 4, NW = 16;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done, sel_dir, line_mode, sense_strobe;
    logic [DW-1:0] rsp_rdata, inh_en;
    logic [XN-1:0] sel_x;
    logic [YN-1:0] sel_y;

    int errors = 0, checks = 0;
    logic [DW-1:0] mdl [NW];
    logic [DW-1:0] exp_rdata = '0;

    always #10 clk = ~clk;

    core_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_DLY(AD), .WRITE_LEN(WL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sel_x(sel_x), .sel_y(sel_y),
        .sel_dir(sel_dir), .inh_en(inh_en), .line_mode(line_mode),
        .sense_strobe(sense_strobe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    // One access, checking every clock from acceptance to the return of ready.
    task automatic do_op(input logic [1:0] op, input int a, input logic [DW-1:0] wd, input bit poke);
        logic [DW-1:0] old, store;
        logic [XN-1:0] ex;
        logic [YN-1:0] ey;
        old   = mdl[a];
        store = (op == 2'b01) ? wd : (op == 2'b10) ? old + 1'b1 : old;
        ex    = XN'(1) << (a % XN);
        ey    = YN'(1) << (a / XN);
        @(negedge clk);
        chk(req_ready === 1'b1, "R10 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_wdata = wd;
        @(posedge clk);
        for (int cyc = 1; cyc <= AD + WL + 2; cyc++) begin
            @(negedge clk);
            if (cyc == 1) begin
                if (poke) begin
                    req_op = 2'b01; req_wdata = ~wd; req_addr = AW'(a);
                end else req_valid = 1'b0;
            end
            if (cyc <= AD) begin
                chk(sel_dir === 1'b0 && sel_x === ex && sel_y === ey, "R11 sense-phase select",
                    {sel_dir, 7'b0, 4'b0, sel_y, 4'b0, sel_x}, {8'b0, 4'b0, ey, 4'b0, ex});
                chk(sense_strobe === (cyc == AD), "R2 strobe timing", 32'(sense_strobe), 32'(cyc == AD));
                chk(line_mode === 1'b0, "R3 sense mode", 32'(line_mode), 0);
                chk(inh_en === '0, "R5 no inhibit in sense", 32'(inh_en), 0);
                chk(rsp_done === 1'b0 && req_ready === 1'b0, "R10 busy in sense",
                    {rsp_done, req_ready}, 0);
            end else if (cyc <= AD + WL) begin
                chk(sel_dir === 1'b1 && sel_x === ex && sel_y === ey, "R4 restore-phase select",
                    {sel_dir, sel_y, sel_x}, {1'b1, ey, ex});
                chk(line_mode === 1'b1 && sense_strobe === 1'b0, "R3 inhibit mode",
                    {line_mode, sense_strobe}, 2'b10);
                chk(inh_en === ~store, "R5 inhibit pattern", 32'(inh_en), 32'(~store));
                chk(rsp_done === 1'b0 && req_ready === 1'b0, "R10 busy in restore",
                    {rsp_done, req_ready}, 0);
            end else if (cyc == AD + WL + 1) begin
                if (poke) req_valid = 1'b0;
                chk(rsp_done === 1'b1 && req_ready === 1'b0, "R10 done pulse",
                    {rsp_done, req_ready}, 2'b10);
                chk(sel_x === '0 && sel_y === '0 && inh_en === '0 && line_mode === 1'b0,
                    "R3 lines released", {sel_x, sel_y, inh_en}, 0);
                if (op != 2'b01) exp_rdata = old;
                chk(rsp_rdata === exp_rdata,
                    (op == 2'b00) ? "R6 read data" : (op == 2'b01) ? "R7 rdata held" :
                    (op == 2'b10) ? "R8 increment returns original" : "R9 alt code data",
                    32'(rsp_rdata), 32'(exp_rdata));
            end else begin
                chk(rsp_done === 1'b0 && req_ready === 1'b1, "R10 ready returns",
                    {rsp_done, req_ready}, 2'b01);
            end
        end
        mdl[a] = store;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && rsp_done === 1'b0 && sense_strobe === 1'b0 && sel_dir === 1'b0 &&
            line_mode === 1'b0 && sel_x === '0 && sel_y === '0 && inh_en === '0,
            "R1 reset state", {req_ready, rsp_done, sense_strobe, sel_dir, line_mode}, 5'b10000);
        rst_n = 1'b1;
        for (int a = 0; a < NW; a++) mdl[a] = '0;
        // R7: fill every word
        for (int a = 0; a < NW; a++) do_op(2'b01, a, pat(a), 1'b0);
        // R6: read sweep twice, proving the restore
        for (int pass = 0; pass < 2; pass++)
            for (int a = 0; a < NW; a++) do_op(2'b00, a, '0, 1'b0);
        // R8: increment and wrap
        do_op(2'b10, 5, '0, 1'b0);
        do_op(2'b00, 5, '0, 1'b0);
        chk(exp_rdata === pat(5) + 8'd1, "R8 incremented value stored", 32'(exp_rdata), 32'(pat(5) + 8'd1));
        do_op(2'b01, 3, 8'hFF, 1'b0);
        do_op(2'b10, 3, '0, 1'b0);
        do_op(2'b00, 3, '0, 1'b0);
        chk(exp_rdata === 8'h00, "R8 wrap to zero", 32'(exp_rdata), 0);
        // R9: alternate code behaves as read
        do_op(2'b11, 9, '0, 1'b0);
        do_op(2'b00, 9, '0, 1'b0);
        chk(exp_rdata === pat(9), "R9 word unchanged", 32'(exp_rdata), 32'(pat(9)));
        // R7: all-zero and all-one words, rdata held across writes
        do_op(2'b01, 0, 8'h00, 1'b0);
        do_op(2'b00, 0, '0, 1'b0);
        do_op(2'b01, 15, 8'hA5, 1'b0);
        do_op(2'b00, 15, '0, 1'b0);
        // R10: request held during busy must be ignored
        do_op(2'b01, 7, 8'h3C, 1'b1);
        do_op(2'b00, 7, '0, 1'b0);
        chk(exp_rdata === 8'h3C, "R10 busy request ignored", 32'(exp_rdata), 32'h3C);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule